// File: doc/BRIEF.md
# Parallel LCD Write Cycle Sequencer

This block generates one 8080-style parallel write transaction to an LCD panel module per accepted request. A request carries a one-bit address/command selector, a data word and four 4-bit timing fields. The sequencer places the selector on the address output, then walks through four timed phases. Each phase lasts its programmed field value plus one clock. The phases are: address lead before chip select, chip-select lead before write enable, the write-enable pulse itself, and a trailing hold during which chip select stays low after write enable has risen.

All timing counts cycles of the clock that runs the block. A valid/ready handshake sits on the request side. The timing fields are captured when a request is accepted, so a controller can reprogram them for the next transfer while the current one runs. A request may be presented in the very cycle a transfer ends, which gives back-to-back transfers with the shortest legal gap on chip select.

Top module: `lcd_wr_seq`

## Requirements
- R1: After a synchronous active-high reset and while idle, `lcdCsN` and `lcdWrN` are 1, `reqReady` is 1 and `done` is 0; a `reqValid` of 0 starts nothing.
- R2: If a request is accepted at clock edge k, `lcdAddr` shows `reqAddr` from the cycle after edge k onward and stays unchanged until the next accept. `lcdCsN` falls `csSetup`+1 cycles after `lcdAddr` changes.
- R3: `lcdWrN` falls `wrSetup`+1 cycles after `lcdCsN` falls.
- R4: `lcdWrN` stays low for exactly `wrActive`+1 cycles.
- R5: After `lcdWrN` rises, `lcdCsN` stays low for exactly `wrHold`+1 cycles, then rises; `lcdWrN` is never low while `lcdCsN` is high.
- R6: `lcdData` equals the accepted `reqData` from the cycle `lcdWrN` falls until `lcdCsN` rises, and keeps that value while idle.
- R7: A request is taken only when `reqValid` and `reqReady` are both 1. `reqReady` is 0 from the cycle after an accept until the cycle `lcdCsN` rises, and it is 1 in that cycle.
- R8: The four timing fields, `reqAddr` and `reqData` are sampled at accept. Changes to them during a transfer do not alter that transfer's timing, address or data.
- R9: A request presented in the cycle `lcdCsN` rises is accepted at the next edge, so `lcdCsN` is high for `csSetup`+2 cycles between the two transfers.
- R10: `done` is 1 for exactly one cycle: the cycle in which `lcdCsN` rises at the end of a transfer.
- R11: Reset asserted in the middle of a transfer returns the block to idle at the next edge, with `lcdCsN`=1, `lcdWrN`=1, `reqReady`=1 and `done`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal video clock; all phase timing counts its cycles |
| rst | input | 1 | Synchronous active-high reset |
| reqValid | input | 1 | Write request present |
| reqReady | output | 1 | Sequencer can accept a request |
| reqAddr | input | 1 | Address/command selector for the transfer |
| reqData | input | DW | Data word to write |
| csSetup | input | TW | Address-to-chip-select lead, in cycles minus one |
| wrSetup | input | TW | Chip-select-to-write-enable lead, in cycles minus one |
| wrActive | input | TW | Write-enable low width, in cycles minus one |
| wrHold | input | TW | Chip-select hold after write enable, in cycles minus one |
| lcdAddr | output | 1 | Address/command line to the panel |
| lcdCsN | output | 1 | Chip select, active low |
| lcdWrN | output | 1 | Write enable, active low |
| lcdData | output | DW | Parallel data bus to the panel |
| done | output | 1 | One-cycle pulse as a transfer ends |

## Verification
On every cycle, the assertions check several properties. Write enable must sit inside chip select, and ready must stay low while chip select is low. The done pulse must be one cycle wide and must line up with the rising edge of chip select. The address and data must be held steady while busy and while write enable is low. The exact phase lengths, and their dependence on the values captured at accept rather than the live field inputs, can only be shown by the bench. It sweeps every combination of small field values, plus maximum and mixed values. It also runs the back-to-back gap, mid-transfer field changes and a reset inside a transfer, and compares each edge time against arithmetic on the fields.

// File: rtl/lcd_wr_pkg.sv
package lcd_wr_pkg;

  // Strobes from the sequencing control into the datapath.
  typedef struct packed {
    logic capture;  // take request word, selector and timing fields
    logic launch;   // drive the captured word onto the panel bus
  } lcdStrobe_t;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR_LEAD,
    PH_CS_LEAD,
    PH_WR_LOW,
    PH_CS_TAIL
  } lcdPhase_t;

endpackage

// File: rtl/lcd_wr_dpath.sv
module lcd_wr_dpath
  import lcd_wr_pkg::*;
#(
  parameter int DW = 8,
  parameter int TW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  lcdStrobe_t    strobe,
  input  logic          reqAddr,
  input  logic [DW-1:0] reqData,
  input  logic [TW-1:0] wrSetup,
  input  logic [TW-1:0] wrActive,
  input  logic [TW-1:0] wrHold,
  output logic [TW-1:0] wrSetupQ,
  output logic [TW-1:0] wrActiveQ,
  output logic [TW-1:0] wrHoldQ,
  output logic          lcdAddr,
  output logic [DW-1:0] lcdData
);

  localparam logic [TW-1:0] ActiveDefault = TW'(1);

  logic [DW-1:0] dataPend;

  // Timing fields captured at accept; defaults mirror the power-on values.
  always_ff @(posedge clk) begin
    if (rst) begin
      wrSetupQ  <= '0;
      wrActiveQ <= ActiveDefault;
      wrHoldQ   <= '0;
    end else if (strobe.capture) begin
      wrSetupQ  <= wrSetup;
      wrActiveQ <= wrActive;
      wrHoldQ   <= wrHold;
    end
  end

  // Selector goes out at once; the word waits for the write-enable phase.
  always_ff @(posedge clk) begin
    if (rst) begin
      lcdAddr  <= 1'b0;
      dataPend <= '0;
      lcdData  <= '0;
    end else begin
      if (strobe.capture) begin
        lcdAddr  <= reqAddr;
        dataPend <= reqData;
      end
      if (strobe.launch) lcdData <= dataPend;
    end
  end

  p_launch_after_capture_r6 : assert property (@(posedge clk) disable iff (rst)
    strobe.launch |-> !strobe.capture);

endmodule

// File: rtl/lcd_wr_ctrl.sv
module lcd_wr_ctrl
  import lcd_wr_pkg::*;
#(
  parameter int TW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reqValid,
  input  logic [TW-1:0] csSetup,
  input  logic [TW-1:0] wrSetupQ,
  input  logic [TW-1:0] wrActiveQ,
  input  logic [TW-1:0] wrHoldQ,
  output logic          reqReady,
  output lcdStrobe_t    strobe,
  output logic          lcdCsN,
  output logic          lcdWrN,
  output logic          done
);

  lcdPhase_t phase, phaseNext;
  logic [TW-1:0] cnt, cntNext;
  logic phaseEnd;

  assign reqReady = (phase == PH_IDLE);
  assign phaseEnd = (cnt == '0);

  always_comb begin
    phaseNext = phase;
    cntNext   = phaseEnd ? cnt : cnt - 1'b1;
    strobe    = '0;
    unique case (phase)
      PH_IDLE: begin
        cntNext = cnt;
        if (reqValid) begin
          strobe.capture = 1'b1;
          phaseNext      = PH_ADDR_LEAD;
          cntNext        = csSetup;
        end
      end
      PH_ADDR_LEAD: if (phaseEnd) begin
        phaseNext = PH_CS_LEAD;
        cntNext   = wrSetupQ;
      end
      PH_CS_LEAD: if (phaseEnd) begin
        phaseNext     = PH_WR_LOW;
        cntNext       = wrActiveQ;
        strobe.launch = 1'b1;
      end
      PH_WR_LOW: if (phaseEnd) begin
        phaseNext = PH_CS_TAIL;
        cntNext   = wrHoldQ;
      end
      PH_CS_TAIL: if (phaseEnd) phaseNext = PH_IDLE;
      default: phaseNext = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase  <= PH_IDLE;
      cnt    <= '0;
      lcdCsN <= 1'b1;
      lcdWrN <= 1'b1;
      done   <= 1'b0;
    end else begin
      phase  <= phaseNext;
      cnt    <= cntNext;
      lcdCsN <= !(phaseNext inside {PH_CS_LEAD, PH_WR_LOW, PH_CS_TAIL});
      lcdWrN <= (phaseNext != PH_WR_LOW);
      done   <= (phase == PH_CS_TAIL) && phaseEnd;
    end
  end

  p_wr_inside_cs_r5 : assert property (@(posedge clk) disable iff (rst)
    !lcdWrN |-> !lcdCsN);
  p_busy_not_ready_r7 : assert property (@(posedge clk) disable iff (rst)
    !lcdCsN |-> !reqReady);
  p_done_single_r10 : assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  p_done_on_rise_r10 : assert property (@(posedge clk) disable iff (rst)
    done |-> $rose(lcdCsN));
  p_rise_gives_done_r10 : assert property (@(posedge clk) disable iff (rst)
    $rose(lcdCsN) && !$past(rst) |-> done);

endmodule

// File: rtl/lcd_wr_seq.sv
module lcd_wr_seq
  import lcd_wr_pkg::*;
#(
  parameter int DW = 8,
  parameter int TW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reqValid,
  output logic          reqReady,
  input  logic          reqAddr,
  input  logic [DW-1:0] reqData,
  input  logic [TW-1:0] csSetup,
  input  logic [TW-1:0] wrSetup,
  input  logic [TW-1:0] wrActive,
  input  logic [TW-1:0] wrHold,
  output logic          lcdAddr,
  output logic          lcdCsN,
  output logic          lcdWrN,
  output logic [DW-1:0] lcdData,
  output logic          done
);

  lcdStrobe_t strobe;
  logic [TW-1:0] wrSetupQ, wrActiveQ, wrHoldQ;

  lcd_wr_ctrl #(.TW(TW)) i_ctrl (
    .clk(clk), .rst(rst), .reqValid(reqValid), .csSetup(csSetup),
    .wrSetupQ(wrSetupQ), .wrActiveQ(wrActiveQ), .wrHoldQ(wrHoldQ),
    .reqReady(reqReady), .strobe(strobe), .lcdCsN(lcdCsN),
    .lcdWrN(lcdWrN), .done(done)
  );

  lcd_wr_dpath #(.DW(DW), .TW(TW)) i_dpath (
    .clk(clk), .rst(rst), .strobe(strobe), .reqAddr(reqAddr),
    .reqData(reqData), .wrSetup(wrSetup), .wrActive(wrActive),
    .wrHold(wrHold), .wrSetupQ(wrSetupQ), .wrActiveQ(wrActiveQ),
    .wrHoldQ(wrHoldQ), .lcdAddr(lcdAddr), .lcdData(lcdData)
  );

  p_addr_steady_r2 : assert property (@(posedge clk) disable iff (rst)
    !reqReady && $past(!reqReady) |-> $stable(lcdAddr));
  p_data_steady_r6 : assert property (@(posedge clk) disable iff (rst)
    $past(!lcdWrN) && !lcdCsN |-> $stable(lcdData));

endmodule

// File: tb/test_lcd_wr_seq.sv
`timescale 1ns/1ps
module test_lcd_wr_seq;
  localparam int DW = 8;
  localparam int TW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reqValid = 1'b0, reqAddr = 1'b0;
  logic [DW-1:0] reqData = '0;
  logic [TW-1:0] csSetup = '0, wrSetup = '0, wrActive = '0, wrHold = '0;
  logic reqReady, lcdAddr, lcdCsN, lcdWrN, done;
  logic [DW-1:0] lcdData;

  always #2.5 clk = ~clk;

  lcd_wr_seq #(.DW(DW), .TW(TW)) i_lcd_wr_seq (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqReady(reqReady),
    .reqAddr(reqAddr), .reqData(reqData), .csSetup(csSetup),
    .wrSetup(wrSetup), .wrActive(wrActive), .wrHold(wrHold),
    .lcdAddr(lcdAddr), .lcdCsN(lcdCsN), .lcdWrN(lcdWrN),
    .lcdData(lcdData), .done(done)
  );

  int cyc = 0, vecs = 0, fails = 0, lastRise = 0;
  logic [DW-1:0] lastData = '0;

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog R1 act=%0d exp=%0d", cyc, 150000);
      $display("  == %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    vecs++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // R1 idle state and R6 data retention; R7 nothing starts without valid.
  task automatic idleCheck(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(lcdCsN && lcdWrN, "R1 idle strobes high", {lcdCsN, lcdWrN}, 3);
      chk(reqReady && !done, "R1 idle ready/done", {reqReady, done}, 2);
      chk(lcdData == lastData, "R6 idle data held", lcdData, lastData);
    end
  endtask

  // Called at a negedge; returns at the negedge of the done cycle.
  task automatic xfer(input int cs, input int ws, input int wa, input int wh,
                      input logic a, input logic [DW-1:0] d,
                      input bit mutate, input bit b2b);
    int tAcc, tCsF = -1, tWrF = -1, tWrR = -1, tCsR = -1;
    bit dataOk = 1, readyOk = 1, doneOk = 1;
    logic pcs, pwr;
    reqValid = 1'b1; reqAddr = a; reqData = d;
    csSetup = TW'(cs); wrSetup = TW'(ws); wrActive = TW'(wa); wrHold = TW'(wh);
    while (!reqReady) @(negedge clk);
    tAcc = cyc;
    if (b2b) chk(tAcc == lastRise, "R9 accept in done cycle", tAcc, lastRise);
    pcs = lcdCsN; pwr = lcdWrN;
    @(negedge clk);
    reqValid = 1'b0;
    chk(lcdAddr == a, "R2 address after accept", lcdAddr, a);
    if (mutate) begin
      csSetup = ~csSetup; wrSetup = ~wrSetup; wrActive = ~wrActive; wrHold = ~wrHold;
      reqAddr = ~a; reqData = ~d;
    end
    forever begin
      if (pcs && !lcdCsN) tCsF = cyc;
      if (pwr && !lcdWrN) tWrF = cyc;
      if (!pwr && lcdWrN) tWrR = cyc;
      if (!pcs && lcdCsN) begin
        tCsR = cyc;
        break;
      end
      if (tWrF >= 0 && lcdData !== d) dataOk = 0;
      if (reqReady) readyOk = 0;
      if (done) doneOk = 0;
      pcs = lcdCsN; pwr = lcdWrN;
      @(negedge clk);
    end
    chk(tCsF == tAcc + cs + 2, "R2 cs fall time", tCsF, tAcc + cs + 2);
    chk(tWrF == tCsF + ws + 1, "R3 wr fall time", tWrF, tCsF + ws + 1);
    chk(tWrR == tWrF + wa + 1, "R4 wr low width", tWrR - tWrF, wa + 1);
    chk(tCsR == tWrR + wh + 1, "R5 cs hold", tCsR - tWrR, wh + 1);
    chk(dataOk, "R6 data valid window", dataOk, 1);
    chk(readyOk && reqReady, "R7 ready low while busy, high at end", readyOk, 1);
    chk(doneOk && done, "R10 done only at cs rise", doneOk + 2 * done, 3);
    chk(lcdAddr == a, "R8 captured address kept", lcdAddr, a);
    lastRise = tCsR;
    lastData = d;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(lcdCsN && lcdWrN && reqReady && !done, "R1 reset state",
        {lcdCsN, lcdWrN, reqReady, done}, 14);
    rst = 1'b0;
    reqAddr = 1'b1; reqData = 8'hA5; csSetup = 4'd3;
    idleCheck(4);  // R7: valid low, no transfer starts

    // R2..R6 sweep: every field in 0..2
    for (int c = 0; c < 3; c++)
      for (int s = 0; s < 3; s++)
        for (int w = 0; w < 3; w++)
          for (int h = 0; h < 3; h++) begin
            xfer(c, s, w, h, logic'((c + s + w + h) & 1),
                 DW'(c * 27 + s * 9 + w * 3 + h + 1), 1'b0, 1'b0);
            idleCheck(1);
          end

    // Extremes
    xfer(15, 15, 15, 15, 1'b1, 8'hF0, 1'b0, 1'b0); idleCheck(2);
    xfer(0, 15, 0, 15, 1'b0, 8'h0F, 1'b0, 1'b0); idleCheck(1);
    xfer(15, 0, 15, 0, 1'b1, 8'h3C, 1'b0, 1'b0); idleCheck(1);

    // R8: fields, selector and word change after accept
    xfer(3, 2, 4, 1, 1'b1, 8'h5A, 1'b1, 1'b0); idleCheck(2);
    xfer(0, 0, 1, 0, 1'b0, 8'hC3, 1'b1, 1'b0); idleCheck(2);

    // R9: back-to-back chain
    xfer(1, 0, 1, 0, 1'b1, 8'h11, 1'b0, 1'b0);
    xfer(0, 0, 0, 0, 1'b0, 8'h22, 1'b0, 1'b1);
    xfer(2, 1, 0, 3, 1'b1, 8'h33, 1'b0, 1'b1);
    xfer(0, 3, 2, 0, 1'b0, 8'h44, 1'b0, 1'b1);
    idleCheck(3);

    // R11: reset inside a transfer (cs low, wr low by cycle 10)
    reqValid = 1'b1; csSetup = 4'd1; wrSetup = 4'd1; wrActive = 4'd9; wrHold = 4'd5;
    reqData = 8'h99;
    @(negedge clk);
    reqValid = 1'b0;
    repeat (6) @(negedge clk);
    chk(!lcdCsN && !lcdWrN && !reqReady, "R11 mid-transfer state before reset",
        {lcdCsN, lcdWrN, reqReady}, 0);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(lcdCsN && lcdWrN && reqReady && !done, "R11 idle after reset",
        {lcdCsN, lcdWrN, reqReady, done}, 14);
    lastData = lcdData;
    idleCheck(2);
    xfer(1, 1, 1, 1, 1'b1, 8'h77, 1'b0, 1'b0);
    idleCheck(2);

    $display("  == %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end
endmodule